// File: doc/BRIEF.md
# Multi-slope ADC modulation sequencer

This block is the digital controller for a discrete multi-slope integrating converter. It drives the analog switch selects that steer a positive or a negative reference current into an external integrator, and it reads a single comparator bit that tells whether the integrator sits above or below its zero level. A conversion starts with a run-up made of a programmable number of modulation cycles. Each cycle has phases of fixed polarity plus phases whose polarity is picked at run time from the comparator, so that the integrator is pushed back toward zero. The block counts the phases driven with each polarity.

After run-up, the residual charge is removed by a rundown that is timed in clock cycles. The rundown ends when the comparator changes state. An optional second, slow rundown then runs in the opposite direction through a low-current path, and its clock count is reported separately. Every change of polarity passes through a programmable dead-time with all switches open. The host combines the up, down and rundown counts into a reading. Two patterns are offered: a four-step cycle and a three-step cycle, which has shorter fixed phases and more transitions per unit of time.

Top module: `msadc_seq`

## Requirements
- R1: After reset, `sw_pos`, `sw_neg`, `sw_lo` and `done` are low, and every result field is zero.
- R2: `sw_pos` and `sw_neg` are never high in the same cycle.
- R3: With phase length L, a four-step cycle drives positive for L clocks, then variable for L clocks, then negative for L clocks, then variable for L clocks. A three-step cycle drives positive for floor(L/2) clocks, then negative for floor(L/2) clocks, then variable for L clocks. The first driven clock of a conversion is positive. Total run-up on-time is `cfg_cycles` times the on-length of one cycle.
- R4: A variable phase is positive when the synchronized comparator is high at the phase boundary, and negative otherwise. `up_cnt` counts run-up phases driven positive and `dn_cnt` counts run-up phases driven negative. A phase counts once even when it joins a neighbour of the same polarity without a gap.
- R5: When the drive changes (positive, negative or low-current variant) from a driven state, all selects are low for exactly `cfg_dead` clocks. If `cfg_dead` is 0, the change is immediate. Consecutive phases with the same drive run without a gap.
- R6: The fast rundown is positive if the comparator is high at the end of run-up, and negative otherwise. It ends when the synchronized comparator differs from that value. `fast_cnt` equals the number of clocks the fast rundown switch was on. A comparator change applied after the k-th on clock gives a count of k+2.
- R7: With `cfg_slow_en` high, a slow rundown follows with the opposite polarity and `sw_lo` high. It ends when the comparator returns to its end-of-run-up value, and `slow_cnt` counts its on clocks (k+2 as in R6). With `cfg_slow_en` low there is no slow drive and `slow_cnt` is 0.
- R8: If a rundown reaches `cfg_rd_max` on clocks without a crossing, it stops, its count equals `cfg_rd_max` and `timeout` is 1. After a fast timeout, the slow rundown is skipped.
- R9: `start` begins a conversion only while the block is idle. A pulse during a conversion has no effect.
- R10: When a conversion completes, the result fields update and `done` is high for exactly one clock. At all other times the result fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a conversion (taken only when idle) |
| cmp_in | input | 1 | asynchronous comparator, high = integrator above zero |
| cfg_cycles | input | CYC_W | modulation cycles in run-up |
| cfg_phase_len | input | PH_W | phase length L in clocks |
| cfg_dead | input | DT_W | break-before-make dead-time in clocks |
| cfg_three_step | input | 1 | 1 = three-step pattern, 0 = four-step |
| cfg_slow_en | input | 1 | enable slow rundown |
| cfg_rd_max | input | RD_W | rundown timeout in clocks |
| sw_pos | output | 1 | positive reference switch select |
| sw_neg | output | 1 | negative reference switch select |
| sw_lo | output | 1 | low-current path select (slow rundown) |
| done | output | 1 | one-cycle result strobe |
| up_cnt | output | CYC_W+2 | positive run-up phases |
| dn_cnt | output | CYC_W+2 | negative run-up phases |
| fast_cnt | output | RD_W | fast rundown clocks |
| slow_cnt | output | RD_W | slow rundown clocks |
| timeout | output | 1 | a rundown hit cfg_rd_max |

## Verification
The switch selects are registered, so a `start` seen at one edge drives `sw_pos` from that same edge. A comparator change takes three edges to open the rundown switch: two synchronizer flops and the state register. This is why the bench expects k+2 on-clocks after a change placed behind the k-th on clock. `done` and the results appear one edge after the rundown switch opens. The bench samples every output at the falling edge. It counts on-clocks, gap lengths and polarity at the pins in that order, and moves the comparator only at those sample points, so each expected count follows from clock arithmetic alone.

// File: rtl/msadc_pkg.sv
package msadc_pkg;
  typedef enum logic [1:0] {DRV_OFF = 2'd0, DRV_POS = 2'd1, DRV_NEG = 2'd2} drv_e;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_DEAD = 3'd1, ST_RUN = 3'd2,
    ST_FAST = 3'd3, ST_SLOW = 3'd4, ST_DONE = 3'd5
  } st_e;
  typedef struct packed {
    st_e  st;
    drv_e drv;
    logic lo;
    st_e  pst;
    drv_e pdrv;
    logic plo;
  } move_t;
endpackage

// File: rtl/msadc_sync.sv
module msadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/msadc_pattern.sv
module msadc_pattern
  import msadc_pkg::*;
#(
  parameter int PH_W = 16
) (
  input  logic [1:0]      idx,
  input  logic            three_step,
  input  logic            cmp_hi,
  input  logic [PH_W-1:0] phase_len,
  output drv_e            drv,
  output logic [PH_W-1:0] len,
  output logic            last
);
  drv_e            steer;
  logic [PH_W-1:0] half;
  assign steer = cmp_hi ? DRV_POS : DRV_NEG;
  assign half  = phase_len >> 1;

  always_comb begin
    drv  = steer;
    len  = phase_len;
    last = 1'b0;
    if (three_step) begin
      case (idx)
        2'd0:    begin drv = DRV_POS; len = half; end
        2'd1:    begin drv = DRV_NEG; len = half; end
        default: begin drv = steer;   last = 1'b1; end
      endcase
    end else begin
      case (idx)
        2'd0:    drv = DRV_POS;
        2'd2:    drv = DRV_NEG;
        2'd3:    last = 1'b1;
        default: drv = steer;
      endcase
    end
  end
endmodule

// File: rtl/msadc_counter.sv
module msadc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (clr) q <= {{(W-1){1'b0}}, inc};
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
  import msadc_pkg::*;
#(
  parameter int CYC_W       = 20,
  parameter int PH_W        = 16,
  parameter int DT_W        = 8,
  parameter int RD_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               cmp_in,
  input  logic [CYC_W-1:0]   cfg_cycles,
  input  logic [PH_W-1:0]    cfg_phase_len,
  input  logic [DT_W-1:0]    cfg_dead,
  input  logic               cfg_three_step,
  input  logic               cfg_slow_en,
  input  logic [RD_W-1:0]    cfg_rd_max,
  output logic               sw_pos,
  output logic               sw_neg,
  output logic               sw_lo,
  output logic               done,
  output logic [CYC_W+1:0]   up_cnt,
  output logic [CYC_W+1:0]   dn_cnt,
  output logic [RD_W-1:0]    fast_cnt,
  output logic [RD_W-1:0]    slow_cnt,
  output logic               timeout
);
  localparam int CNT_W = CYC_W + 2;
  localparam int TM_W  = (PH_W > DT_W) ? PH_W : DT_W;

  // state
  st_e              st_r, nxt_st, pst_r, nxt_pst;
  drv_e             drv_r, nxt_drv, pdrv_r, nxt_pdrv;
  logic             lo_r, nxt_lo, plo_r, nxt_plo;
  logic [TM_W-1:0]  tmr_r, nxt_tmr;
  logic [1:0]       idx_r, nxt_idx, nidx, pat_idx;
  logic [CYC_W-1:0] cyc_r, nxt_cyc;
  logic [PH_W-1:0]  len_r, nxt_len;
  logic             last_r, nxt_last;
  logic [RD_W-1:0]  fc_r, nxt_fc, sc_r, nxt_sc;
  logic             c0_r, nxt_c0, to_r, nxt_to;

  logic             cmp_s;
  drv_e             pat_drv;
  logic [PH_W-1:0]  pat_len;
  logic             pat_last;
  logic             cnt_clr;
  logic [1:0]       cnt_inc;
  logic [CNT_W-1:0] cnt_q [2];
  logic             take;
  move_t            mv;

  logic [TM_W:0]    tmr_inc;
  logic [CYC_W:0]   cyc_inc;
  logic [RD_W:0]    fc_inc, sc_inc;
  logic             use_dead;

  msadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cmp_in), .q(cmp_s)
  );

  // next phase lookup: index 0 when starting, else successor of current
  assign nidx    = last_r ? 2'd0 : idx_r + 2'd1;
  assign pat_idx = (st_r == ST_IDLE) ? 2'd0 : nidx;

  msadc_pattern #(.PH_W(PH_W)) u_pat (
    .idx(pat_idx), .three_step(cfg_three_step), .cmp_hi(cmp_s),
    .phase_len(cfg_phase_len), .drv(pat_drv), .len(pat_len), .last(pat_last)
  );

  // index 0 counts positive phases, index 1 negative phases
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    msadc_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc[g]), .q(cnt_q[g])
    );
  end

  assign tmr_inc  = {1'b0, tmr_r} + 1'b1;
  assign cyc_inc  = {1'b0, cyc_r} + 1'b1;
  assign fc_inc   = {1'b0, fc_r} + 1'b1;
  assign sc_inc   = {1'b0, sc_r} + 1'b1;
  assign use_dead = (cfg_dead != '0);

  // move to a new drive, inserting an open interval when the drive changes
  function automatic move_t plan_move(drv_e cur, logic cur_lo, drv_e tgt,
                                      logic tgt_lo, st_e tgt_st, logic dead_on);
    move_t m;
    m.pst  = tgt_st;
    m.pdrv = tgt;
    m.plo  = tgt_lo;
    if (dead_on && cur != DRV_OFF && (tgt != cur || tgt_lo != cur_lo)) begin
      m.st = ST_DEAD; m.drv = DRV_OFF; m.lo = 1'b0;
    end else begin
      m.st = tgt_st;  m.drv = tgt;     m.lo = tgt_lo;
    end
    return m;
  endfunction

  always_comb begin
    nxt_st = st_r;   nxt_drv = drv_r;   nxt_lo = lo_r;
    nxt_pst = pst_r; nxt_pdrv = pdrv_r; nxt_plo = plo_r;
    nxt_tmr = tmr_r; nxt_idx = idx_r;   nxt_cyc = cyc_r;
    nxt_len = len_r; nxt_last = last_r;
    nxt_fc = fc_r;   nxt_sc = sc_r;     nxt_c0 = c0_r; nxt_to = to_r;
    cnt_clr = 1'b0;  cnt_inc = 2'b00;   take = 1'b0;
    mv = plan_move(drv_r, lo_r, drv_r, lo_r, st_r, 1'b0);
    case (st_r)
      ST_IDLE: begin
        if (start) begin
          nxt_idx = 2'd0; nxt_cyc = '0; nxt_fc = '0; nxt_sc = '0; nxt_to = 1'b0;
          nxt_len = pat_len; nxt_last = pat_last;
          cnt_clr = 1'b1;
          cnt_inc = {pat_drv == DRV_NEG, pat_drv == DRV_POS};
          mv = plan_move(drv_r, lo_r, pat_drv, 1'b0, ST_RUN, use_dead);
          take = 1'b1;
        end
      end
      ST_DEAD: begin
        if (tmr_inc >= {{(TM_W+1-DT_W){1'b0}}, cfg_dead}) begin
          nxt_st = pst_r; nxt_drv = pdrv_r; nxt_lo = plo_r; nxt_tmr = '0;
        end else begin
          nxt_tmr = tmr_inc[TM_W-1:0];
        end
      end
      ST_RUN: begin
        if (tmr_inc >= {{(TM_W+1-PH_W){1'b0}}, len_r}) begin
          if (last_r && cyc_inc >= {1'b0, cfg_cycles}) begin
            nxt_c0 = cmp_s;
            nxt_fc = '0;
            mv = plan_move(drv_r, lo_r, cmp_s ? DRV_POS : DRV_NEG, 1'b0,
                           ST_FAST, use_dead);
          end else begin
            nxt_idx = nidx;
            if (last_r) nxt_cyc = cyc_inc[CYC_W-1:0];
            nxt_len = pat_len; nxt_last = pat_last;
            cnt_inc = {pat_drv == DRV_NEG, pat_drv == DRV_POS};
            mv = plan_move(drv_r, lo_r, pat_drv, 1'b0, ST_RUN, use_dead);
          end
          take = 1'b1;
        end else begin
          nxt_tmr = tmr_inc[TM_W-1:0];
        end
      end
      ST_FAST: begin
        nxt_fc = fc_inc[RD_W-1:0];
        if (cmp_s != c0_r) begin
          if (cfg_slow_en) begin
            nxt_sc = '0;
            mv = plan_move(drv_r, lo_r, c0_r ? DRV_NEG : DRV_POS, 1'b1,
                           ST_SLOW, use_dead);
            take = 1'b1;
          end else begin
            nxt_st = ST_DONE; nxt_drv = DRV_OFF; nxt_lo = 1'b0;
          end
        end else if (fc_inc >= {1'b0, cfg_rd_max}) begin
          nxt_to = 1'b1;
          nxt_st = ST_DONE; nxt_drv = DRV_OFF; nxt_lo = 1'b0;
        end
      end
      ST_SLOW: begin
        nxt_sc = sc_inc[RD_W-1:0];
        if (cmp_s == c0_r) begin
          nxt_st = ST_DONE; nxt_drv = DRV_OFF; nxt_lo = 1'b0;
        end else if (sc_inc >= {1'b0, cfg_rd_max}) begin
          nxt_to = 1'b1;
          nxt_st = ST_DONE; nxt_drv = DRV_OFF; nxt_lo = 1'b0;
        end
      end
      default: nxt_st = ST_IDLE;
    endcase
    if (take) begin
      nxt_st = mv.st;   nxt_drv = mv.drv;   nxt_lo = mv.lo;
      nxt_pst = mv.pst; nxt_pdrv = mv.pdrv; nxt_plo = mv.plo;
      nxt_tmr = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_r <= ST_IDLE;  pst_r <= ST_IDLE;
      drv_r <= DRV_OFF; pdrv_r <= DRV_OFF;
      lo_r <= 1'b0;     plo_r <= 1'b0;
      tmr_r <= '0; idx_r <= '0; cyc_r <= '0; len_r <= '0; last_r <= 1'b0;
      fc_r <= '0;  sc_r <= '0;  c0_r <= 1'b0; to_r <= 1'b0;
      sw_pos <= 1'b0; sw_neg <= 1'b0; sw_lo <= 1'b0; done <= 1'b0;
      up_cnt <= '0; dn_cnt <= '0; fast_cnt <= '0; slow_cnt <= '0; timeout <= 1'b0;
    end else begin
      st_r <= nxt_st;   pst_r <= nxt_pst;
      drv_r <= nxt_drv; pdrv_r <= nxt_pdrv;
      lo_r <= nxt_lo;   plo_r <= nxt_plo;
      tmr_r <= nxt_tmr; idx_r <= nxt_idx; cyc_r <= nxt_cyc;
      len_r <= nxt_len; last_r <= nxt_last;
      fc_r <= nxt_fc;   sc_r <= nxt_sc;   c0_r <= nxt_c0; to_r <= nxt_to;
      sw_pos <= (nxt_drv == DRV_POS);
      sw_neg <= (nxt_drv == DRV_NEG);
      sw_lo  <= nxt_lo;
      done   <= (st_r == ST_DONE);
      if (st_r == ST_DONE) begin
        up_cnt   <= cnt_q[0];
        dn_cnt   <= cnt_q[1];
        fast_cnt <= fc_r;
        slow_cnt <= sc_r;
        timeout  <= to_r;
      end
    end
  end
endmodule

// File: rtl/msadc_seq_chk.sv
module msadc_seq_chk #(
  parameter int CNT_W = 22,
  parameter int DT_W  = 8,
  parameter int RD_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_pos,
  input logic             sw_neg,
  input logic             done,
  input logic [CNT_W-1:0] up_cnt,
  input logic [CNT_W-1:0] dn_cnt,
  input logic [RD_W-1:0]  fast_cnt,
  input logic [RD_W-1:0]  slow_cnt,
  input logic             timeout,
  input logic [DT_W-1:0]  cfg_dead,
  input logic [RD_W-1:0]  cfg_rd_max
);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sw_pos && sw_neg));

  a_r5_bbm_pos_neg: assert property (@(posedge clk) disable iff (rst)
    (cfg_dead != '0 && $past(sw_pos)) |-> !sw_neg);

  a_r5_bbm_neg_pos: assert property (@(posedge clk) disable iff (rst)
    (cfg_dead != '0 && $past(sw_neg)) |-> !sw_pos);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_results_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(up_cnt) && $stable(dn_cnt) && $stable(fast_cnt) &&
               $stable(slow_cnt) && $stable(timeout)));

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    (done && cfg_rd_max != '0) |-> (fast_cnt <= cfg_rd_max && slow_cnt <= cfg_rd_max));

  a_r8_timeout_at_max: assert property (@(posedge clk) disable iff (rst)
    (done && timeout) |-> (fast_cnt == cfg_rd_max || slow_cnt == cfg_rd_max));
endmodule

bind msadc_seq msadc_seq_chk #(.CNT_W(CNT_W), .DT_W(DT_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst(rst), .sw_pos(sw_pos), .sw_neg(sw_neg), .done(done),
  .up_cnt(up_cnt), .dn_cnt(dn_cnt), .fast_cnt(fast_cnt), .slow_cnt(slow_cnt),
  .timeout(timeout), .cfg_dead(cfg_dead), .cfg_rd_max(cfg_rd_max)
);

// File: tb/tb_msadc_seq.sv
module tb_msadc_seq;
  localparam int CYC_W = 20, PH_W = 16, DT_W = 8, RD_W = 16, CNT_W = CYC_W + 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, cmp_in = 1'b0;
  logic [CYC_W-1:0] cfg_cycles = '0;
  logic [PH_W-1:0]  cfg_phase_len = '0;
  logic [DT_W-1:0]  cfg_dead = '0;
  logic             cfg_three_step = 1'b0, cfg_slow_en = 1'b0;
  logic [RD_W-1:0]  cfg_rd_max = '0;
  logic sw_pos, sw_neg, sw_lo, done, timeout;
  logic [CNT_W-1:0] up_cnt, dn_cnt;
  logic [RD_W-1:0]  fast_cnt, slow_cnt;

  msadc_seq dut (
    .clk(clk), .rst(rst), .start(start), .cmp_in(cmp_in),
    .cfg_cycles(cfg_cycles), .cfg_phase_len(cfg_phase_len), .cfg_dead(cfg_dead),
    .cfg_three_step(cfg_three_step), .cfg_slow_en(cfg_slow_en), .cfg_rd_max(cfg_rd_max),
    .sw_pos(sw_pos), .sw_neg(sw_neg), .sw_lo(sw_lo), .done(done),
    .up_cnt(up_cnt), .dn_cnt(dn_cnt), .fast_cnt(fast_cnt), .slow_cnt(slow_cnt),
    .timeout(timeout)
  );

  always #10 clk = ~clk;

  int checks = 0, bad = 0;
  typedef struct { int up; int dn; int fc; int sc; bit to; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops an expected item for every strobe
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(up_cnt) == e.up, "R4", "up_cnt", int'(up_cnt), e.up);
          chk(int'(dn_cnt) == e.dn, "R4", "dn_cnt", int'(dn_cnt), e.dn);
          chk(int'(fast_cnt) == e.fc, "R6", "fast_cnt", int'(fast_cnt), e.fc);
          chk(int'(slow_cnt) == e.sc, "R7", "slow_cnt", int'(slow_cnt), e.sc);
          chk(timeout == e.to, "R8", "timeout", int'(timeout), int'(e.to));
        end
        @(negedge clk);
        chk(!done, "R10", "done width", int'(done), 0);
      end
    end
  end

  // driver: one conversion, pushes the expectation and plays the comparator
  task automatic run_conv(input int n, input int l, input int d, input bit three,
                          input bit slow, input bit c, input int f, input int s,
                          input int rdmax, input bit poke);
    exp_t e;
    int run_tot, onc, gap, prev_sel, fobs, sobs, err_x, err_g, err_p, gap_a, cyc;
    bit poked, first;
    logic [2:0] sel;
    logic [CNT_W-1:0] h_up;
    logic [RD_W-1:0] h_fc;
    @(negedge clk);
    cfg_cycles = CYC_W'(n); cfg_phase_len = PH_W'(l); cfg_dead = DT_W'(d);
    cfg_three_step = three; cfg_slow_en = slow; cfg_rd_max = RD_W'(rdmax);
    cmp_in = c;
    if (three) begin e.up = c ? 2*n : n; e.dn = c ? n : 2*n; run_tot = n*(2*(l/2)+l); end
    else       begin e.up = c ? 3*n : n; e.dn = c ? n : 3*n; run_tot = n*4*l; end
    e.to = 1'b0; e.sc = 0;
    if (f + 2 > rdmax) begin e.fc = rdmax; e.to = 1'b1; end
    else begin
      e.fc = f + 2;
      if (slow) begin
        if (s + 2 > rdmax) begin e.sc = rdmax; e.to = 1'b1; end
        else e.sc = s + 2;
      end
    end
    sb.push_back(e);
    repeat (3) @(negedge clk);
    start = 1'b1;
    onc = 0; gap = 0; prev_sel = -1; fobs = 0; sobs = 0;
    err_x = 0; err_g = 0; err_p = 0; gap_a = 0; poked = 1'b0; first = 1'b1; cyc = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (first) begin
        chk(sw_pos && !sw_neg, "R3", "first phase positive", int'(sw_pos), 1);
        first = 1'b0;
      end
      sel = {sw_lo, sw_pos, sw_neg};
      if (sw_pos && sw_neg) err_x++;
      if (sw_pos || sw_neg) begin
        if (prev_sel >= 0 && int'(sel) != prev_sel && gap != d) begin err_g++; gap_a = gap; end
        if (prev_sel >= 0 && int'(sel) == prev_sel && gap != 0) begin err_g++; gap_a = gap; end
        gap = 0; prev_sel = int'(sel); onc++;
        if (onc > run_tot) begin
          if (!sw_lo) begin
            fobs++;
            if (sw_pos != c) err_p++;
            if (fobs == f) cmp_in = ~c;
          end else begin
            sobs++;
            if (sw_pos == c) err_p++;
            if (sobs == s) cmp_in = c;
          end
        end
        if (poke && !poked && onc == run_tot/2) begin start = 1'b1; poked = 1'b1; end
      end else if (prev_sel >= 0) gap++;
      if (done || cyc > 20000) break;
    end
    chk(err_x == 0, "R2", "both selects high", err_x, 0);
    chk(err_g == 0, "R5", "dead-time gap", gap_a, d);
    chk(err_p == 0, "R6", "rundown polarity errors", err_p, 0);
    chk(fobs == e.fc, "R6", "fast on-clocks at pins", fobs, e.fc);
    chk(sobs == e.sc, "R7", "slow on-clocks at pins", sobs, e.sc);
    chk(onc == run_tot + e.fc + e.sc, "R3", "total on-clocks", onc, run_tot + e.fc + e.sc);
    h_up = up_cnt; h_fc = fast_cnt;
    if (poke) begin
      int extra = 0;
      repeat (40) begin
        @(negedge clk);
        if (sw_pos || sw_neg || done) extra++;
      end
      chk(extra == 0, "R9", "activity after ignored start", extra, 0);
      chk(up_cnt == h_up && fast_cnt == h_fc, "R10", "results held", int'(up_cnt), int'(h_up));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sw_pos && !sw_neg && !sw_lo, "R1", "switches after reset", int'({sw_pos, sw_neg, sw_lo}), 0);
    chk(!done && up_cnt == '0 && dn_cnt == '0 && fast_cnt == '0 && slow_cnt == '0 && !timeout,
        "R1", "results after reset", int'(up_cnt), 0);
    run_conv(4, 8, 2, 1'b0, 1'b1, 1'b1, 10, 6, 200, 1'b0);    // R3 R4 four-step high
    run_conv(3, 6, 3, 1'b0, 1'b0, 1'b0, 5, 0, 200, 1'b0);     // R7 slow disabled
    run_conv(5, 8, 1, 1'b1, 1'b1, 1'b1, 7, 3, 200, 1'b0);     // three-step high
    run_conv(2, 10, 0, 1'b1, 1'b1, 1'b0, 4, 9, 200, 1'b0);    // R5 zero dead-time
    run_conv(2, 4, 2, 1'b0, 1'b1, 1'b1, 1000, 0, 30, 1'b0);   // R8 fast timeout
    run_conv(2, 8, 2, 1'b1, 1'b1, 1'b0, 3, 1000, 25, 1'b0);   // R8 slow timeout
    run_conv(3, 8, 2, 1'b0, 1'b1, 1'b0, 6, 4, 200, 1'b1);     // R9 start while busy
    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R10", "pending results", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule